// File: doc/BRIEF.md
# Bus-Invert Link Coder

This block lowers switching activity on a parallel data bus. A transmit stage accepts a data word together with a valid strobe. It counts how many bus lines would change if the word were driven as it is, measured against the levels the lines currently carry. If more than half of them would toggle, it drives the bitwise complement of the word instead and raises a single extra polarity line. Across a sequence of transfers this bounds the data-line activity per transfer to half the bus width.

A receive stage in the same clock domain captures the lines and the polarity flag. One cycle later it produces the restored word with a valid output. The bus and the flag hold their levels whenever no word is offered, so idle cycles cost no transitions. Reset clears the lines and the flag, and those zero levels are the reference for the first comparison.

Top module: `bic_link`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `bus_lines` is all zero, `bus_flag` is 0 and `out_valid` is 0; those zero levels are the reference for the first word sent.
- R2: The toggle count for a new word is taken against the levels `bus_lines` actually carries, which may be inverted, and not against the previous raw word.
- R3: When `in_valid` is sampled high and more than DATA_W/2 lines would toggle, on the next cycle `bus_flag` is 1 and every bit of `bus_lines` is the complement of the word.
- R4: When `in_valid` is sampled high and DATA_W/2 or fewer lines would toggle, including exactly half, on the next cycle `bus_flag` is 0 and `bus_lines` equals the word.
- R5: When `in_valid` is low, `bus_lines` and `bus_flag` keep their levels and `in_data` has no effect.
- R6: No transfer toggles more than DATA_W/2 of the data lines.
- R7: A word sampled with `in_valid` at clock edge n appears on `out_data` with `out_valid` high after edge n+2, restored as the captured lines XOR the replicated flag; `out_valid` is low in every other cycle.
- R8: Over any run, the transitions on data lines plus flag never exceed the transitions plain transmission would make plus the flag toggles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | A word is offered this cycle |
| in_data | input | DATA_W | Word to transmit |
| bus_lines | output | DATA_W | Coded data lines as driven |
| bus_flag | output | 1 | Polarity line, 1 = lines carry the complement |
| out_valid | output | 1 | Restored word valid |
| out_data | output | DATA_W | Restored word |

## Verification
The bench builds the coder with the default width of eight lines. An even width makes the exact-half tie reachable, so the keep-true-polarity rule is exercised directly. It also makes words reachable whose raw value repeats while the lines sit inverted, which separates comparing against the driven levels from comparing against the last raw word. Random streams at this width cover both polarities, back-to-back transfers and idle gaps with changing input data.

// File: rtl/bic_pkg.sv
package bic_pkg;

    // Polarity carried on the extra line
    typedef enum logic {
        POL_TRUE = 1'b0,
        POL_INV  = 1'b1
    } bic_pol_e;

    // Width of a population count for a vector of w bits
    function automatic int cnt_width(input int w);
        return $clog2(w + 1);
    endfunction

endpackage

// File: rtl/bic_popcount.sv
module bic_popcount #(
    parameter int W  = 8,
    parameter int CW = 4
) (
    input  logic [W-1:0]  vec,
    output logic [CW-1:0] cnt
);
    // Ripple chain of partial sums, one stage per bit
    logic [CW-1:0] part [W+1];

    assign part[0] = '0;

    genvar i;
    generate
        for (i = 0; i < W; i++) begin : g_stage
            assign part[i+1] = part[i] + CW'(vec[i]);
        end
    endgenerate

    assign cnt = part[W];

endmodule

// File: rtl/bic_tx.sv
module bic_tx
    import bic_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         word_vld,
    input  logic [W-1:0] word,
    output logic [W-1:0] lines,
    output logic         flag,
    output logic         fire
);
    localparam int CW   = cnt_width(W);
    localparam int HALF = W / 2;

    typedef struct packed {
        logic [W-1:0] lines;
        bic_pol_e     pol;
        logic         fire;
    } tx_t;

    tx_t s_d, s_q;

    logic [W-1:0]  diff;
    logic [CW-1:0] toggles;
    bic_pol_e      pol_sel;

    // Distance between the candidate word and the levels now on the lines
    assign diff = word ^ s_q.lines;

    bic_popcount #(.W(W), .CW(CW)) u_cnt (
        .vec (diff),
        .cnt (toggles)
    );

    always_comb begin
        pol_sel = (toggles > CW'(HALF)) ? POL_INV : POL_TRUE;
        s_d      = s_q;
        s_d.fire = 1'b0;
        if (word_vld) begin
            s_d.lines = word ^ {W{pol_sel == POL_INV}};
            s_d.pol   = pol_sel;
            s_d.fire  = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q.lines <= '0;
            s_q.pol   <= POL_TRUE;
            s_q.fire  <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign lines = s_q.lines;
    assign flag  = (s_q.pol == POL_INV);
    assign fire  = s_q.fire;

endmodule

// File: rtl/bic_rx.sv
module bic_rx #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] lines,
    input  logic         flag,
    input  logic         fire,
    output logic [W-1:0] word,
    output logic         word_vld
);
    typedef struct packed {
        logic [W-1:0] cap_lines;
        logic         cap_flag;
        logic         cap_vld;
        logic [W-1:0] out_word;
        logic         out_vld;
    } rx_t;

    rx_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        // Capture stage: load only when a transfer occurred
        s_d.cap_vld = fire;
        if (fire) begin
            s_d.cap_lines = lines;
            s_d.cap_flag  = flag;
        end
        // Restore stage
        s_d.out_vld = s_q.cap_vld;
        if (s_q.cap_vld) begin
            s_d.out_word = s_q.cap_lines ^ {W{s_q.cap_flag}};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign word     = s_q.out_word;
    assign word_vld = s_q.out_vld;

endmodule

// File: rtl/bic_link.sv
module bic_link #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    output logic [DATA_W-1:0] bus_lines,
    output logic              bus_flag,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data
);
    logic tx_fire;

    bic_tx #(.W(DATA_W)) u_tx (
        .clk      (clk),
        .rst      (rst),
        .word_vld (in_valid),
        .word     (in_data),
        .lines    (bus_lines),
        .flag     (bus_flag),
        .fire     (tx_fire)
    );

    bic_rx #(.W(DATA_W)) u_rx (
        .clk      (clk),
        .rst      (rst),
        .lines    (bus_lines),
        .flag     (bus_flag),
        .fire     (tx_fire),
        .word     (out_data),
        .word_vld (out_valid)
    );

endmodule

// File: rtl/bic_link_chk.sv
module bic_link_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic [DATA_W-1:0] in_data,
    input logic [DATA_W-1:0] bus_lines,
    input logic              bus_flag,
    input logic              out_valid,
    input logic [DATA_W-1:0] out_data
);
    localparam int HALF = DATA_W / 2;

    assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (bus_lines == '0) && !bus_flag && !out_valid);

    assert_invert_majority_R3: assert property (@(posedge clk) disable iff (rst)
        (in_valid && ($countones(in_data ^ bus_lines) > HALF))
        |=> bus_flag && (bus_lines == ~$past(in_data)));

    assert_keep_polarity_R4: assert property (@(posedge clk) disable iff (rst)
        (in_valid && ($countones(in_data ^ bus_lines) <= HALF))
        |=> !bus_flag && (bus_lines == $past(in_data)));

    assert_idle_hold_R5: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(bus_lines) && $stable(bus_flag));

    assert_toggle_bound_R6: assert property (@(posedge clk) disable iff (rst)
        $countones(bus_lines ^ $past(bus_lines)) <= HALF);

    assert_restore_word_R7: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(in_valid, 3) && (out_data == $past(in_data, 3))
                      && (out_data == $past(bus_lines ^ {DATA_W{bus_flag}}, 2)));

endmodule

bind bic_link bic_link_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/bic_link_tb.sv
`timescale 1ns/1ps
module bic_link_tb;
    localparam int W    = 8;
    localparam int HALF = W / 2;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic [W-1:0] in_data = '0;
    logic [W-1:0] bus_lines;
    logic         bus_flag;
    logic         out_valid;
    logic [W-1:0] out_data;

    bic_link #(.DATA_W(W)) u_dut (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .bus_lines (bus_lines),
        .bus_flag  (bus_flag),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

    always #2.5 clk = ~clk;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [W-1:0] exp_q [$];
    logic [W-1:0] model_bus = '0;
    logic         model_flag = 1'b0;
    logic [W-1:0] plain_prev = '0;
    int plain_tog = 0;
    int coded_tog = 0;
    int flag_tog = 0;
    int data_tog = 0;
    logic [W-1:0] mon_exp;

    function automatic void check(bit ok, string req, string what, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endfunction

    // Monitor: compare restored words against the scoreboard (R7)
    always @(negedge clk) begin
        if (!rst && out_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R7", "out_valid with no word pending", 1, 0);
            end else begin
                mon_exp = exp_q.pop_front();
                check(out_data == mon_exp, "R7", "restored word", int'(out_data), int'(mon_exp));
            end
        end
    end

    // Driver: called at a negedge, leaves in_valid high
    task automatic send(input logic [W-1:0] d);
        int   t;
        logic inv;
        logic [W-1:0] e;
        string tag;
        t   = $countones(d ^ model_bus);
        inv = (t > HALF);
        e   = d ^ {W{inv}};
        tag = inv ? "R3" : "R4";
        in_valid = 1'b1;
        in_data  = d;
        exp_q.push_back(d);
        @(negedge clk);
        check(bus_lines == e, tag, "bus lines", int'(bus_lines), int'(e));
        check(bus_flag == inv, tag, "polarity flag", int'(bus_flag), int'(inv));
        check($countones(bus_lines ^ model_bus) <= HALF, "R6", "data line toggles",
              $countones(bus_lines ^ model_bus), HALF);
        data_tog  += $countones(bus_lines ^ model_bus);
        flag_tog  += int'(bus_flag != model_flag);
        coded_tog += $countones(bus_lines ^ model_bus) + int'(bus_flag != model_flag);
        plain_tog += $countones(d ^ plain_prev);
        plain_prev = d;
        model_bus  = bus_lines;
        model_flag = bus_flag;
    endtask

    task automatic idle(input int n);
        in_valid = 1'b0;
        for (int i = 0; i < n; i++) begin
            in_data = W'($urandom);
            @(negedge clk);
            check(bus_lines == model_bus && bus_flag == model_flag, "R5", "hold while idle",
                  int'({bus_flag, bus_lines}), int'({model_flag, model_bus}));
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        in_valid = 1'b0;
        repeat (3) @(negedge clk);
        check(bus_lines == '0 && !bus_flag && !out_valid, "R1", "state in reset",
              int'({out_valid, bus_flag, bus_lines}), 0);
        rst = 1'b0;
        exp_q.delete();
        model_bus  = '0;
        model_flag = 1'b0;
        plain_prev = '0;
        @(negedge clk);
        check(bus_lines == '0 && !bus_flag && !out_valid, "R1", "state after reset",
              int'({out_valid, bus_flag, bus_lines}), 0);
    endtask

    initial begin
        @(negedge clk);
        do_reset();

        // R3: all lines would toggle from the zero reference
        send(8'hFF);
        // R2: same raw word again, lines sit inverted at 00 -> invert again
        send(8'hFF);
        check(bus_lines == 8'h00 && bus_flag, "R2", "compare against driven lines",
              int'({bus_flag, bus_lines}), 9'h100);
        send(8'h00);
        // R4: exactly half toggle keeps true polarity
        send(8'h0F);
        check(!bus_flag, "R4", "tie keeps true polarity", int'(bus_flag), 0);
        send(8'hF0);
        send(8'hE1);
        idle(4);
        send(8'h3C);
        send(8'hC3);
        idle(3);

        for (int i = 0; i < 400; i++) begin
            send(W'($urandom));
            if (($urandom % 6) == 0) idle(1 + int'($urandom % 3));
        end
        idle(5);
        check(exp_q.size() == 0, "R7", "all words restored", exp_q.size(), 0);
        check(coded_tog <= plain_tog + flag_tog, "R8", "coded transitions bound",
              coded_tog, plain_tog + flag_tog);
        check(data_tog <= plain_tog, "R8", "data line transitions vs plain", data_tog, plain_tog);

        // Reset in mid-run, then the zero reference applies again
        send(8'h5A);
        idle(4);
        do_reset();
        send(8'h1F);
        check(bus_lines == 8'hE0 && bus_flag, "R1", "zero reference after reset",
              int'({bus_flag, bus_lines}), 9'h1E0);
        idle(4);
        check(exp_q.size() == 0, "R7", "pipeline drained", exp_q.size(), 0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule